// File: doc/BRIEF.md
# Three-Valued Dual-Rail Logic Unit

This unit evaluates one logic operation on operands that may hold unknown bits. Each bit travels as two wires: a value wire and an unknown flag. A caller presents operand pairs A and B, a one-bit select pair for the mux, and a 4-bit operation code. One registered cycle later the unit returns a result pair of `OUT_W` bits.

Unknowns are not simply merged into the result. A known controlling input decides the output whatever the other input holds: a known 0 decides AND, and a known 1 decides OR. The mux with an unknown select still gives a known bit wherever both data bits agree and are known.

The output stage is a single register with a valid/ready handshake, so a driver can stream one vector per clock.

Top module: `xlogic_unit`

## Requirements
- R1: Code 0, bitwise AND. A result bit is unknown only when an input bit is unknown and neither input bit is a known 0. Otherwise it is the AND of the known values.
- R2: Code 1, bitwise OR. A result bit is unknown only when an input bit is unknown and neither input bit is a known 1. Otherwise it is the OR of the known values.
- R3: Codes 2 (XOR) and 3 (XNOR) give an unknown result bit whenever either input bit is unknown. Code 4 (NOT of A) copies the unknown flag of A.
- R4: Code 5 is the mux. It picks B when the select is a known 1 and A when the select is a known 0, together with that input's unknown flags.
- R5: For code 5 with an unknown select, a result bit is unknown when the A and B bits differ or either one is unknown. Otherwise it is the shared known value.
- R6: Codes 6 (reduce AND), 7 (reduce OR) and 11 (logical NOT of A) work over A's `IN_W` bits. The result is unknown when A has an unknown bit and no known 0 (code 6) or no known 1 (codes 7 and 11) decides it.
- R7: Code 8 (reduce XOR of A) is unknown when any bit of A is unknown. For codes 6 to 11, every result bit above bit 0 is a known 0.
- R8: Codes 9 (logical AND) and 10 (logical OR) treat an operand as known true if it has a known 1, and as known false if all its bits are known 0. The result is unknown only when neither operand alone decides it.
- R9: The value wire of every result bit flagged unknown is 0.
- R10: For bitwise codes 0 to 5, operands are zero-extended from `IN_W` to `OUT_W`. Their extra bits act as known 0.
- R11: Codes 12 to 15 give a result with all unknown flags set and all value bits 0.
- R12: A result appears with out_valid one clock after it is accepted (in_valid and in_ready both high). It stays unchanged while out_ready is low, and in_ready is high exactly when the register is empty or out_ready is high. After reset, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand set is valid |
| in_ready | output | 1 | Unit accepts an operand set this cycle |
| op | input | 4 | Operation code |
| a_val | input | IN_W | Operand A value wire |
| a_unk | input | IN_W | Operand A unknown flags |
| b_val | input | IN_W | Operand B value wire |
| b_unk | input | IN_W | Operand B unknown flags |
| sel_val | input | 1 | Mux select value |
| sel_unk | input | 1 | Mux select unknown flag |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| y_val | output | OUT_W | Result value wire |
| y_unk | output | OUT_W | Result unknown flags |

## Verification
Decoding faults show up at the ports in the cycle right after acceptance. An inverted masking term in AND or OR, or a mux that ignores its unknown select, changes y_unk on the first vector that mixes a known controlling bit with an unknown one. A missing value clear, or a stray high bit in a reduction, shows as a value bit set beside an unknown flag or above bit 0. Faults in the handshake register appear as results that change while they are stalled, or as in_ready values that disagree with the occupancy the bench tracks on each clock.

// File: rtl/xlu_pkg.sv
// Shared operation codes for the three-valued logic unit.
// Assumes a 4-bit code; codes above OP_LNOT are treated as unused.
package xlu_pkg;
    typedef enum logic [3:0] {
        OP_AND  = 4'd0,
        OP_OR   = 4'd1,
        OP_XOR  = 4'd2,
        OP_XNOR = 4'd3,
        OP_NOT  = 4'd4,
        OP_MUX  = 4'd5,
        OP_RAND = 4'd6,
        OP_ROR  = 4'd7,
        OP_RXOR = 4'd8,
        OP_LAND = 4'd9,
        OP_LOR  = 4'd10,
        OP_LNOT = 4'd11
    } xl_op_e;

    localparam logic [3:0] OP_LAST = OP_LNOT;
endpackage

// File: rtl/xlu_bitwise.sv
// Bitwise three-valued operations (AND, OR, XOR, XNOR, NOT, mux) on W-bit pairs.
// Assumes the operands are already extended to W. The value output is not
// canonical; the caller clears value bits that are flagged unknown.
module xlu_bitwise #(
    parameter int W = 8
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] av,
    input  logic [W-1:0] au,
    input  logic [W-1:0] bv,
    input  logic [W-1:0] bu,
    input  logic         sv,
    input  logic         su,
    output logic [W-1:0] yv,
    output logic [W-1:0] yu
);
    import xlu_pkg::*;

    logic [W-1:0] a_k1, a_k0, b_k1, b_k0;

    // Known-one and known-zero masks of each operand.
    always_comb begin
        a_k1 = av & ~au;
        a_k0 = ~av & ~au;
        b_k1 = bv & ~bu;
        b_k0 = ~bv & ~bu;
    end

    // Select the operation and its unknown rule.
    always_comb begin
        yv = '0;
        yu = '0;
        case (op)
            OP_AND: begin
                yu = (au | bu) & ~(a_k0 | b_k0);
                yv = a_k1 & b_k1;
            end
            OP_OR: begin
                yu = (au | bu) & ~(a_k1 | b_k1);
                yv = a_k1 | b_k1;
            end
            OP_XOR: begin
                yu = au | bu;
                yv = av ^ bv;
            end
            OP_XNOR: begin
                yu = au | bu;
                yv = ~(av ^ bv);
            end
            OP_NOT: begin
                yu = au;
                yv = ~av;
            end
            OP_MUX: begin
                if (su) begin
                    yu = (av ^ bv) | au | bu;
                    yv = av & bv;
                end else if (sv) begin
                    yu = bu;
                    yv = bv;
                end else begin
                    yu = au;
                    yv = av;
                end
            end
            default: begin
                yu = '0;
                yv = '0;
            end
        endcase
    end
endmodule

// File: rtl/xlu_reduce.sv
// Single-bit three-valued reductions and logical operations over W-bit operands.
// Assumes operands at their native width, so no zero-extension affects the result.
module xlu_reduce #(
    parameter int W = 8
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] av,
    input  logic [W-1:0] au,
    input  logic [W-1:0] bv,
    input  logic [W-1:0] bu,
    output logic         rv,
    output logic         ru
);
    import xlu_pkg::*;

    logic a_any1, a_any0, a_anyx, a_false;
    logic b_any1, b_anyx, b_false;

    // Summary terms: any known 1, any known 0, any unknown, all known 0.
    always_comb begin
        a_any1  = |(av & ~au);
        a_any0  = |(~av & ~au);
        a_anyx  = |au;
        a_false = ~a_any1 & ~a_anyx;
        b_any1  = |(bv & ~bu);
        b_anyx  = |bu;
        b_false = ~b_any1 & ~b_anyx;
    end

    // Combine the summary terms for the selected reduction.
    always_comb begin
        rv = 1'b0;
        ru = 1'b0;
        case (op)
            OP_RAND: begin
                ru = a_anyx & ~a_any0;
                rv = ~a_any0 & ~a_anyx;
            end
            OP_ROR: begin
                ru = a_anyx & ~a_any1;
                rv = a_any1;
            end
            OP_RXOR: begin
                ru = a_anyx;
                rv = ^av;
            end
            OP_LNOT: begin
                ru = a_anyx & ~a_any1;
                rv = a_false;
            end
            OP_LAND: begin
                ru = (a_anyx | b_anyx) & ~(a_any1 & b_any1) & ~a_false & ~b_false;
                rv = a_any1 & b_any1;
            end
            OP_LOR: begin
                ru = (a_anyx | b_anyx) & ~(a_false & b_false) & ~a_any1 & ~b_any1;
                rv = a_any1 | b_any1;
            end
            default: begin
                rv = 1'b0;
                ru = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/xlu_outreg.sv
// One-entry output register with valid/ready handshake.
// Assumes the producer holds its data only in the cycle it is accepted.
module xlu_outreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] d_val,
    input  logic [W-1:0] d_unk,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] y_val,
    output logic [W-1:0] y_unk
);
    // The register can load when it is empty or being drained.
    assign in_ready = ~out_valid | out_ready;

    // Load a new result or hold the current one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            y_val     <= '0;
            y_unk     <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) begin
                y_val <= d_val;
                y_unk <= d_unk;
            end
        end
    end
endmodule

// File: rtl/xlogic_unit.sv
// Top of the three-valued logic unit: extends operands, runs the bitwise and
// reduction paths, picks one by code, clears value bits that are unknown, and
// registers the result. Assumes OUT_W >= IN_W and OUT_W >= 2.
module xlogic_unit #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [3:0]       op,
    input  logic [IN_W-1:0]  a_val,
    input  logic [IN_W-1:0]  a_unk,
    input  logic [IN_W-1:0]  b_val,
    input  logic [IN_W-1:0]  b_unk,
    input  logic             sel_val,
    input  logic             sel_unk,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] y_val,
    output logic [OUT_W-1:0] y_unk
);
    import xlu_pkg::*;

    localparam int PAD_W = OUT_W - IN_W;

    logic [OUT_W-1:0] ax_v, ax_u, bx_v, bx_u;
    logic [OUT_W-1:0] bw_v, bw_u;
    logic             rd_v, rd_u;
    logic [OUT_W-1:0] nx_v, nx_u;

    // Zero-extension: extra bits are known 0.
    generate
        if (PAD_W > 0) begin : g_pad
            assign ax_v = {{PAD_W{1'b0}}, a_val};
            assign ax_u = {{PAD_W{1'b0}}, a_unk};
            assign bx_v = {{PAD_W{1'b0}}, b_val};
            assign bx_u = {{PAD_W{1'b0}}, b_unk};
        end else begin : g_same
            assign ax_v = a_val;
            assign ax_u = a_unk;
            assign bx_v = b_val;
            assign bx_u = b_unk;
        end
    endgenerate

    xlu_bitwise #(.W(OUT_W)) u_bitwise (
        .op (op),
        .av (ax_v),
        .au (ax_u),
        .bv (bx_v),
        .bu (bx_u),
        .sv (sel_val),
        .su (sel_unk),
        .yv (bw_v),
        .yu (bw_u)
    );

    xlu_reduce #(.W(IN_W)) u_reduce (
        .op (op),
        .av (a_val),
        .au (a_unk),
        .bv (b_val),
        .bu (b_unk),
        .rv (rd_v),
        .ru (rd_u)
    );

    // Pick the path by code, flag unused codes, and make the value wire canonical.
    always_comb begin
        if (op <= OP_MUX) begin
            nx_u = bw_u;
            nx_v = bw_v;
        end else if (op <= OP_LAST) begin
            nx_u = {{(OUT_W-1){1'b0}}, rd_u};
            nx_v = {{(OUT_W-1){1'b0}}, rd_v};
        end else begin
            nx_u = '1;
            nx_v = '0;
        end
        nx_v = nx_v & ~nx_u;
    end

    xlu_outreg #(.W(OUT_W)) u_outreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .d_val     (nx_v),
        .d_unk     (nx_u),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .y_val     (y_val),
        .y_unk     (y_unk)
    );
endmodule

// File: rtl/xlogic_unit_chk.sv
// Port-level properties of the three-valued logic unit, bound to every instance.
// Assumes the code map in xlu_pkg.
module xlogic_unit_chk #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [3:0]       op,
    input logic [IN_W-1:0]  a_unk,
    input logic [IN_W-1:0]  b_unk,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OUT_W-1:0] y_val,
    input logic [OUT_W-1:0] y_unk
);
    logic taken;
    assign taken = in_valid && in_ready;

    // R9
    canon_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((y_val & y_unk) == '0));

    // R12
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(y_val) && $stable(y_unk)));

    // R7
    reduce_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && op >= 4'd6 && op <= 4'd11) |=>
            (y_val[OUT_W-1:1] == '0 && y_unk[OUT_W-1:1] == '0));

    // R11
    unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && op >= 4'd12) |=> (y_unk == '1 && y_val == '0));

    // R3
    xor_unknown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && op == 4'd2) |=> (y_unk[IN_W-1:0] == $past(a_unk | b_unk)));
endmodule

bind xlogic_unit xlogic_unit_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .op        (op),
    .a_unk     (a_unk),
    .b_unk     (b_unk),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .y_val     (y_val),
    .y_unk     (y_unk)
);

// File: tb/xlogic_unit_test.sv
`timescale 1ns/1ps
module xlogic_unit_test;
    localparam int IN_W  = 8;
    localparam int OUT_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [3:0]       op = '0;
    logic [IN_W-1:0]  a_val = '0, a_unk = '0, b_val = '0, b_unk = '0;
    logic             sel_val = 1'b0, sel_unk = 1'b0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [OUT_W-1:0] y_val, y_unk;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [OUT_W-1:0] q_v[$];
    logic [OUT_W-1:0] q_u[$];
    string            q_r[$];
    logic [3:0]       q_op[$];

    always #2.5 clk = ~clk;

    xlogic_unit #(.IN_W(IN_W), .OUT_W(OUT_W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .op(op), .a_val(a_val), .a_unk(a_unk), .b_val(b_val), .b_unk(b_unk),
        .sel_val(sel_val), .sel_unk(sel_unk), .out_valid(out_valid),
        .out_ready(out_ready), .y_val(y_val), .y_unk(y_unk)
    );

    // Three-valued bit: 0, 1, or 2 for unknown.
    function automatic int tv(input logic v, input logic u);
        return u ? 2 : (v ? 1 : 0);
    endfunction
    function automatic int t_and(input int x, input int y);
        if (x == 0 || y == 0) return 0;
        if (x == 2 || y == 2) return 2;
        return 1;
    endfunction
    function automatic int t_or(input int x, input int y);
        if (x == 1 || y == 1) return 1;
        if (x == 2 || y == 2) return 2;
        return 0;
    endfunction
    function automatic int t_xor(input int x, input int y);
        if (x == 2 || y == 2) return 2;
        return x ^ y;
    endfunction
    function automatic int t_not(input int x);
        return (x == 2) ? 2 : 1 - x;
    endfunction

    function automatic string req_of(input logic [3:0] o, input logic su);
        case (o)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2, 4'd3, 4'd4: return "R3";
            4'd5: return su ? "R5" : "R4";
            4'd6, 4'd7, 4'd11: return "R6";
            4'd8: return "R7";
            4'd9, 4'd10: return "R8";
            default: return "R11";
        endcase
    endfunction

    // Reference: evaluate the operation bit by bit in three-valued terms.
    function automatic void model(input logic [3:0] o,
                                  input logic [IN_W-1:0] av, au, bv, bu,
                                  input logic sv, su,
                                  output logic [OUT_W-1:0] ev, eu);
        int ta[OUT_W];
        int tb[OUT_W];
        int r[OUT_W];
        int s;
        int ra, rb;
        for (int i = 0; i < OUT_W; i++) begin
            ta[i] = (i < IN_W) ? tv(av[i], au[i]) : 0;
            tb[i] = (i < IN_W) ? tv(bv[i], bu[i]) : 0;
            r[i]  = 0;
        end
        s = tv(sv, su);
        ra = 0;
        rb = 0;
        for (int i = 0; i < IN_W; i++) begin
            ra = t_or(ra, ta[i]);
            rb = t_or(rb, tb[i]);
        end
        case (o)
            4'd0: for (int i = 0; i < OUT_W; i++) r[i] = t_and(ta[i], tb[i]);
            4'd1: for (int i = 0; i < OUT_W; i++) r[i] = t_or(ta[i], tb[i]);
            4'd2: for (int i = 0; i < OUT_W; i++) r[i] = t_xor(ta[i], tb[i]);
            4'd3: for (int i = 0; i < OUT_W; i++) r[i] = t_not(t_xor(ta[i], tb[i]));
            4'd4: for (int i = 0; i < OUT_W; i++) r[i] = t_not(ta[i]);
            4'd5: for (int i = 0; i < OUT_W; i++)
                      r[i] = (s == 0) ? ta[i] : (s == 1) ? tb[i] :
                             ((ta[i] == tb[i] && ta[i] != 2) ? ta[i] : 2);
            4'd6: begin
                r[0] = 1;
                for (int i = 0; i < IN_W; i++) r[0] = t_and(r[0], ta[i]);
            end
            4'd7: r[0] = ra;
            4'd8: begin
                r[0] = 0;
                for (int i = 0; i < IN_W; i++) r[0] = t_xor(r[0], ta[i]);
            end
            4'd9:  r[0] = t_and(ra, rb);
            4'd10: r[0] = t_or(ra, rb);
            4'd11: r[0] = t_not(ra);
            default: for (int i = 0; i < OUT_W; i++) r[i] = 2;
        endcase
        for (int i = 0; i < OUT_W; i++) begin
            ev[i] = (r[i] == 1);
            eu[i] = (r[i] == 2);
        end
    endfunction

    task automatic chk(input bit ok, input string r,
                       input logic [2*OUT_W-1:0] act, input logic [2*OUT_W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", r, act, exp, $time);
        end
    endtask

    // Compare the output port against the model's occupancy and front entry.
    task automatic check_out();
        if (q_v.size() == 0) begin
            chk(out_valid === 1'b0, "R12", {{(2*OUT_W-1){1'b0}}, out_valid}, '0);
        end else begin
            chk(out_valid === 1'b1, "R12", {{(2*OUT_W-1){1'b0}}, out_valid}, 1);
            chk({y_unk, y_val} === {q_u[0], q_v[0]}, q_r[0], {y_unk, y_val}, {q_u[0], q_v[0]});
            chk((y_val & y_unk) === '0, "R9", {y_unk, y_val}, {q_u[0], q_v[0]});
            if (q_op[0] <= 4'd5)
                chk({y_unk[OUT_W-1:IN_W], y_val[OUT_W-1:IN_W]} ===
                    {q_u[0][OUT_W-1:IN_W], q_v[0][OUT_W-1:IN_W]}, "R10",
                    {y_unk, y_val}, {q_u[0], q_v[0]});
        end
    endtask

    task automatic step(input logic iv, input logic [3:0] o,
                        input logic [IN_W-1:0] av, au, bv, bu,
                        input logic sv, su, input logic ordy);
        logic [OUT_W-1:0] ev, eu;
        logic exp_rdy;
        @(negedge clk);
        check_out();
        in_valid = iv; op = o;
        a_val = av; a_unk = au; b_val = bv; b_unk = bu;
        sel_val = sv; sel_unk = su; out_ready = ordy;
        #1;
        exp_rdy = (q_v.size() == 0) || ordy;
        chk(in_ready === exp_rdy, "R12", {{(2*OUT_W-1){1'b0}}, in_ready},
            {{(2*OUT_W-1){1'b0}}, exp_rdy});
        if (q_v.size() > 0 && ordy) begin
            void'(q_v.pop_front()); void'(q_u.pop_front());
            void'(q_r.pop_front()); void'(q_op.pop_front());
        end
        if (iv && exp_rdy) begin
            model(o, av, au, bv, bu, sv, su, ev, eu);
            q_v.push_back(ev); q_u.push_back(eu);
            q_r.push_back(req_of(o, su)); q_op.push_back(o);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // Reset: out_valid low (R12)
        repeat (3) begin
            @(negedge clk);
            chk(out_valid === 1'b0, "R12", {{(2*OUT_W-1){1'b0}}, out_valid}, '0);
        end
        rst_n = 1'b1;

        // R1: known 0 masks unknown, known 1 does not
        step(1, 4'd0, 8'h0F, 8'hF0, 8'h00, 8'hFF, 0, 0, 1);
        step(1, 4'd0, 8'hFF, 8'h00, 8'h3C, 8'hC3, 0, 0, 1);
        // R2: known 1 masks unknown
        step(1, 4'd1, 8'hF0, 8'h0F, 8'h00, 8'hFF, 0, 0, 1);
        step(1, 4'd1, 8'h00, 8'h00, 8'h55, 8'hAA, 0, 0, 1);
        // R3: XOR, XNOR, NOT; R10 shows upper bits of NOT become known 1
        step(1, 4'd2, 8'hA5, 8'h11, 8'h5A, 8'h80, 0, 0, 1);
        step(1, 4'd3, 8'hA5, 8'h11, 8'h5A, 8'h80, 0, 0, 1);
        step(1, 4'd4, 8'hC3, 8'h18, 8'h00, 8'h00, 0, 0, 1);
        // R4: known selects
        step(1, 4'd5, 8'h12, 8'h01, 8'h34, 8'h40, 0, 0, 1);
        step(1, 4'd5, 8'h12, 8'h01, 8'h34, 8'h40, 1, 0, 1);
        // R5: unknown select, equal known bits survive
        step(1, 4'd5, 8'hF0, 8'h01, 8'hF3, 8'h80, 0, 1, 1);
        // R6: reductions and logical NOT
        step(1, 4'd6, 8'hFF, 8'h00, 8'h00, 8'h00, 0, 0, 1);
        step(1, 4'd6, 8'hFE, 8'h01, 8'h00, 8'h00, 0, 0, 1);
        step(1, 4'd6, 8'h7E, 8'h01, 8'h00, 8'h00, 0, 0, 1);
        step(1, 4'd7, 8'h00, 8'h10, 8'h00, 8'h00, 0, 0, 1);
        step(1, 4'd7, 8'h02, 8'h10, 8'h00, 8'h00, 0, 0, 1);
        step(1, 4'd11, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 1);
        step(1, 4'd11, 8'h00, 8'h04, 8'h00, 8'h00, 0, 0, 1);
        // R7: reduce XOR
        step(1, 4'd8, 8'h07, 8'h00, 8'h00, 8'h00, 0, 0, 1);
        step(1, 4'd8, 8'h07, 8'h80, 8'h00, 8'h00, 0, 0, 1);
        // R8: logical AND / OR
        step(1, 4'd9, 8'h00, 8'h00, 8'h00, 8'hFF, 0, 0, 1);
        step(1, 4'd9, 8'h01, 8'h00, 8'h00, 8'h08, 0, 0, 1);
        step(1, 4'd9, 8'h01, 8'h00, 8'h20, 8'h08, 0, 0, 1);
        step(1, 4'd10, 8'h40, 8'h00, 8'h00, 8'hFF, 0, 0, 1);
        step(1, 4'd10, 8'h00, 8'h00, 8'h00, 8'h02, 0, 0, 1);
        // R11: unused codes
        step(1, 4'd12, 8'hFF, 8'h00, 8'hFF, 8'h00, 0, 0, 1);
        step(1, 4'd15, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 1);
        // R12: stall holds the result, new input refused
        step(1, 4'd0, 8'h0F, 8'h00, 8'h0F, 8'h00, 0, 0, 0);
        step(1, 4'd1, 8'hF0, 8'h00, 8'h0F, 8'h00, 0, 0, 0);
        step(1, 4'd1, 8'hF0, 8'h00, 8'h0F, 8'h00, 0, 0, 0);
        step(0, 4'd0, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 1);
        step(0, 4'd0, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 1);

        // Random traffic across all codes
        for (int n = 0; n < 4000; n++) begin
            logic [IN_W-1:0] ra_u, rb_u;
            ra_u = ($urandom_range(0, 3) == 0) ? '0 : IN_W'($urandom & $urandom & $urandom);
            rb_u = ($urandom_range(0, 3) == 0) ? '0 : IN_W'($urandom & $urandom & $urandom);
            step($urandom_range(0, 4) != 0, 4'($urandom), IN_W'($urandom), ra_u,
                 IN_W'($urandom), rb_u, 1'($urandom), ($urandom_range(0, 2) == 0),
                 $urandom_range(0, 3) != 0);
        end
        step(0, 4'd0, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 1);
        step(0, 4'd0, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule